// File: doc/BRIEF.md
# SD Host Single-Address DMA Engine

This block is the data mover behind an SD host controller's data path. Firmware sets four things through a small register port: a starting memory address, a block size with a boundary code, a block count and a transfer mode word. It then pulses a start input. The engine moves bytes in one of two directions, chosen by the mode word:

- Card to memory: bytes arriving on a byte stream from the card side are written to ascending memory addresses.
- Memory to card: bytes are fetched from ascending memory addresses and sent out on a byte stream toward the card.

Firmware can pick a memory window of 4 KiB shifted left by the boundary code. Whenever the next address falls on a multiple of that window and bytes remain, the engine halts and raises a DMA interrupt flag. It carries on only when firmware writes a new value to the address register. After the final block it raises a transfer-complete flag.

Only the single-address mode is implemented. If firmware selects any of the descriptor modes, the engine reports an error and does not move data. Bit-level line handling and CRC generation sit outside this block; the two byte streams stand in for them.

Top module: `sdma_engine`

## Requirements
- R1: After synchronous reset, the interrupt status (select 5) and error status (select 6) read 0, the address register (select 0) reads 0, `mem_req`, `in_ready`, `out_valid` and `irq` are 0.
- R2: Register selects are 0 address, 1 block size, 2 block count, 3 mode, 4 host control, 5 interrupt status, 6 error status. Block size keeps the size in bits 11:0 and the boundary code in bits 14:12. Mode keeps multi-block in bit 5, direction in bit 4 (1 = card to memory), auto-stop in bit 2, count enable in bit 1 and DMA enable in bit 0. Host control keeps the DMA mode select in bits 4:3. Unlisted bits read 0.
- R3: With direction 1, each byte accepted on the input stream is written to memory at the current address, and the address then increments by one.
- R4: With direction 0, each byte is read from memory at the current address and presented on the output stream in address order.
- R5: When the address after a byte is a multiple of 4 KiB << boundary code and the transfer is not finished, the engine halts and sets interrupt status bit 3. Multiples of smaller powers of two do not halt it.
- R6: While halted, the address register reads the next address to be accessed and no memory access or stream handshake occurs. A write to the address register resumes the transfer from the written address.
- R7: At the end of each block, the block count decrements by one if count enable is 1. If count enable is 0, it is left unchanged.
- R8: Interrupt status bit 1 is set after one block when multi-block is 0, or when the block count reaches zero with multi-block and count enable both 1. Completion takes precedence over a halt on the last byte.
- R9: A start with DMA mode select 01, 10 or 11 sets error status bit 9 and interrupt status bit 15 and moves no data.
- R10: Status bits are cleared by writing 1 to them; writing 0 leaves them unchanged. `irq` is 1 exactly while any status bit is set.
- R11: A start is ignored while DMA enable is 0 or while a transfer is running. An address write during a running transfer is ignored.
- R12: Once `mem_req` is raised, it stays high with address, write flag and write data unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select for writes |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_sel | input | 3 | Register select for reads |
| reg_rd_data | output | 32 | Register read data (combinational) |
| xfer_start | input | 1 | Start pulse for a transfer |
| in_valid | input | 1 | Card-side byte available |
| in_data | input | 8 | Card-side byte |
| in_ready | output | 1 | Engine accepts a card-side byte |
| out_valid | output | 1 | Byte toward the card is valid |
| out_data | output | 8 | Byte toward the card |
| out_ready | input | 1 | Card side accepts the byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access completes this cycle |
| irq | output | 1 | Any status bit set |

## Verification
Several rules are checked by assertions on every cycle:
- the memory request stays stable until acknowledged;
- the address is frozen while halted;
- the block count is untouched when counting is off;
- a halt or completion event is always followed by its status bit;
- an error start leaves the engine idle.

Other behaviour needs the bench's scenarios, which compare every memory write and output byte against a scoreboard. These cover the byte ordering in each direction, where the halt falls for different boundary codes, resuming from a new address, the final block count, and completion taking priority over a halt on the last byte.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    localparam int ADDR_W = 32;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        SEL_ADDR  = 3'd0,
        SEL_SIZE  = 3'd1,
        SEL_COUNT = 3'd2,
        SEL_MODE  = 3'd3,
        SEL_HOST  = 3'd4,
        SEL_INT   = 3'd5,
        SEL_ERR   = 3'd6
    } reg_sel_e;

    // bit positions firmware depends on
    localparam int MD_MULTI  = 5;
    localparam int MD_TO_MEM = 4;
    localparam int MD_ASTOP  = 2;
    localparam int MD_CNT_EN = 1;
    localparam int MD_DMA_EN = 0;
    localparam int IS_DONE   = 1;
    localparam int IS_HALT   = 3;
    localparam int IS_ERR    = 15;
    localparam int ES_DESC   = 9;

    typedef struct packed {
        logic [11:0] blk_size;
        logic [2:0]  bnd_code;
        logic        multi;
        logic        to_mem;
        logic        astop;
        logic        cnt_en;
        logic        dma_en;
        logic [1:0]  mode_sel;
    } cfg_t;

    typedef struct packed {
        logic done;
        logic halt;
        logic err_sum;
        logic desc_err;
    } sts_t;

    typedef struct packed {
        logic done;
        logic halt;
        logic desc_err;
    } evt_t;

    typedef enum logic [1:0] {
        MV_IDLE,
        MV_GET,
        MV_PUT,
        MV_HALT
    } mv_state_e;

    function automatic logic on_boundary(input logic [ADDR_W-1:0] a,
                                         input logic [2:0] code,
                                         input int base_log2);
        logic [ADDR_W-1:0] one;
        logic [ADDR_W-1:0] mask;
        one  = {{(ADDR_W-1){1'b0}}, 1'b1};
        mask = (one << (base_log2 + int'(code))) - one;
        return (a & mask) == '0;
    endfunction

endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
    import sdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  evt_t        evt,
    output cfg_t        cfg,
    output sts_t        sts,
    output logic        addr_wr,
    output logic        cnt_wr
);
    reg_sel_e sel;
    logic hit_size, hit_mode, hit_host, hit_int, hit_err;

    always_comb begin
        sel      = reg_sel_e'(wr_sel);
        addr_wr  = wr_en && (sel == SEL_ADDR);
        cnt_wr   = wr_en && (sel == SEL_COUNT);
        hit_size = wr_en && (sel == SEL_SIZE);
        hit_mode = wr_en && (sel == SEL_MODE);
        hit_host = wr_en && (sel == SEL_HOST);
        hit_int  = wr_en && (sel == SEL_INT);
        hit_err  = wr_en && (sel == SEL_ERR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            if (hit_size) begin
                cfg.blk_size <= wr_data[11:0];
                cfg.bnd_code <= wr_data[14:12];
            end
            if (hit_mode) begin
                cfg.multi  <= wr_data[MD_MULTI];
                cfg.to_mem <= wr_data[MD_TO_MEM];
                cfg.astop  <= wr_data[MD_ASTOP];
                cfg.cnt_en <= wr_data[MD_CNT_EN];
                cfg.dma_en <= wr_data[MD_DMA_EN];
            end
            if (hit_host) begin
                cfg.mode_sel <= wr_data[4:3];
            end
        end
    end

    // events win over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
        end else begin
            sts.done     <= evt.done | (sts.done & ~(hit_int & wr_data[IS_DONE]));
            sts.halt     <= evt.halt | (sts.halt & ~(hit_int & wr_data[IS_HALT]));
            sts.err_sum  <= evt.desc_err | (sts.err_sum & ~(hit_int & wr_data[IS_ERR]));
            sts.desc_err <= evt.desc_err | (sts.desc_err & ~(hit_err & wr_data[ES_DESC]));
        end
    end

    p_done_flag_r8: assert property (@(posedge clk) disable iff (rst)
        evt.done |=> sts.done);
    p_desc_flags_r9: assert property (@(posedge clk) disable iff (rst)
        evt.desc_err |=> (sts.desc_err && sts.err_sum));
    p_w0_keeps_r10: assert property (@(posedge clk) disable iff (rst)
        (sts.done && !(hit_int && wr_data[IS_DONE])) |=> sts.done);

endmodule

// File: rtl/sdma_blk_tracker.sv
module sdma_blk_tracker #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [11:0]      blk_size,
    input  logic             multi,
    input  logic             cnt_en,
    output logic [CNT_W-1:0] blk_cnt,
    output logic             xfer_last
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [11:0] byte_cnt;
    logic [12:0] eff_size;
    logic [12:0] byte_nxt;
    logic        blk_end;
    logic        last_blk;

    always_comb begin
        // a size of zero stands for the largest block
        eff_size  = (blk_size == 12'd0) ? 13'd4096 : {1'b0, blk_size};
        byte_nxt  = {1'b0, byte_cnt} + 13'd1;
        blk_end   = step && (byte_nxt == eff_size);
        last_blk  = !multi || (cnt_en && (blk_cnt == CNT_ONE));
        xfer_last = blk_end && last_blk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_cnt <= '0;
        end else if (load) begin
            byte_cnt <= '0;
        end else if (step) begin
            byte_cnt <= blk_end ? 12'd0 : byte_nxt[11:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_cnt <= '0;
        end else if (cnt_wr) begin
            blk_cnt <= cnt_wdata;
        end else if (blk_end && cnt_en && (blk_cnt != '0)) begin
            blk_cnt <= blk_cnt - CNT_ONE;
        end
    end

    p_cnt_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !cnt_wr) |=> $stable(blk_cnt));
    p_cnt_step_r7: assert property (@(posedge clk) disable iff (rst)
        (blk_end && cnt_en && !cnt_wr && (blk_cnt != '0)) |=> (blk_cnt == $past(blk_cnt) - CNT_ONE));

endmodule

// File: rtl/sdma_mover.sv
module sdma_mover
    import sdma_pkg::*;
#(
    parameter int BND_BASE_LOG2 = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  logic              start,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              xfer_last,
    output cfg_t              run,
    output logic              load,
    output logic              step,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr,
    output evt_t              evt,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    mv_state_e         state;
    logic [BYTE_W-1:0] byte_q;
    logic [ADDR_W-1:0] addr_nxt;
    logic              idle;

    always_comb begin
        idle      = (state == MV_IDLE);
        busy      = !idle;
        addr_nxt  = cur_addr + {{(ADDR_W-1){1'b0}}, 1'b1};
        step      = (state == MV_PUT) && (run.to_mem ? mem_ack : out_ready);
        load      = start && idle && (cfg.mode_sel == 2'b00) && cfg.dma_en;
        evt.done     = step && xfer_last;
        evt.halt     = step && !xfer_last && on_boundary(addr_nxt, run.bnd_code, BND_BASE_LOG2);
        evt.desc_err = start && idle && (cfg.mode_sel != 2'b00);

        in_ready  = (state == MV_GET) && run.to_mem;
        out_valid = (state == MV_PUT) && !run.to_mem;
        out_data  = byte_q;
        mem_req   = ((state == MV_GET) && !run.to_mem) || ((state == MV_PUT) && run.to_mem);
        mem_we    = (state == MV_PUT) && run.to_mem;
        mem_addr  = cur_addr;
        mem_wdata = byte_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= MV_IDLE;
            cur_addr <= '0;
            byte_q   <= '0;
            run      <= '0;
        end else begin
            unique case (state)
                MV_IDLE: begin
                    if (addr_wr) cur_addr <= addr_wdata;
                    if (load) begin
                        run   <= cfg;
                        state <= MV_GET;
                    end
                end
                MV_GET: begin
                    if (run.to_mem) begin
                        if (in_valid) begin
                            byte_q <= in_data;
                            state  <= MV_PUT;
                        end
                    end else if (mem_ack) begin
                        byte_q <= mem_rdata;
                        state  <= MV_PUT;
                    end
                end
                MV_PUT: begin
                    if (step) begin
                        cur_addr <= addr_nxt;
                        if (evt.done)      state <= MV_IDLE;
                        else if (evt.halt) state <= MV_HALT;
                        else               state <= MV_GET;
                    end
                end
                MV_HALT: begin
                    if (addr_wr) begin
                        cur_addr <= addr_wdata;
                        state    <= MV_GET;
                    end
                end
                default: state <= MV_IDLE;
            endcase
        end
    end

    p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    p_halt_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (state == MV_HALT && !addr_wr) |=> $stable(cur_addr));
    p_desc_stays_idle_r9: assert property (@(posedge clk) disable iff (rst)
        evt.desc_err |=> (state == MV_IDLE));
    p_run_addr_fixed_r11: assert property (@(posedge clk) disable iff (rst)
        (state == MV_GET) |=> (cur_addr == $past(cur_addr)));

endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
    import sdma_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int BND_BASE_LOG2 = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic [2:0]  reg_wr_sel,
    input  logic [31:0] reg_wr_data,
    input  logic [2:0]  reg_rd_sel,
    output logic [31:0] reg_rd_data,
    input  logic        xfer_start,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    input  logic        out_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    input  logic        mem_ack,
    output logic        irq
);
    cfg_t             cfg;
    cfg_t             run;
    sts_t             sts;
    evt_t             evt;
    logic             addr_wr, cnt_wr_raw, cnt_wr;
    logic             load, step, busy, xfer_last;
    logic [31:0]      cur_addr;
    logic [CNT_W-1:0] blk_cnt;

    sdma_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_sel  (reg_wr_sel),
        .wr_data (reg_wr_data),
        .evt     (evt),
        .cfg     (cfg),
        .sts     (sts),
        .addr_wr (addr_wr),
        .cnt_wr  (cnt_wr_raw)
    );

    assign cnt_wr = cnt_wr_raw && !busy;

    sdma_blk_tracker #(.CNT_W(CNT_W)) u_trk (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (step),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (reg_wr_data[CNT_W-1:0]),
        .blk_size  (run.blk_size),
        .multi     (run.multi),
        .cnt_en    (run.cnt_en),
        .blk_cnt   (blk_cnt),
        .xfer_last (xfer_last)
    );

    sdma_mover #(.BND_BASE_LOG2(BND_BASE_LOG2)) u_mov (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .start      (xfer_start),
        .addr_wr    (addr_wr),
        .addr_wdata (reg_wr_data),
        .xfer_last  (xfer_last),
        .run        (run),
        .load       (load),
        .step       (step),
        .busy       (busy),
        .cur_addr   (cur_addr),
        .evt        (evt),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_ready  (out_ready),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack)
    );

    always_comb begin
        reg_rd_data = '0;
        unique case (reg_sel_e'(reg_rd_sel))
            SEL_ADDR:  reg_rd_data = cur_addr;
            SEL_SIZE:  reg_rd_data = {17'd0, cfg.bnd_code, cfg.blk_size};
            SEL_COUNT: reg_rd_data = {{(32-CNT_W){1'b0}}, blk_cnt};
            SEL_MODE: begin
                reg_rd_data[MD_MULTI]  = cfg.multi;
                reg_rd_data[MD_TO_MEM] = cfg.to_mem;
                reg_rd_data[MD_ASTOP]  = cfg.astop;
                reg_rd_data[MD_CNT_EN] = cfg.cnt_en;
                reg_rd_data[MD_DMA_EN] = cfg.dma_en;
            end
            SEL_HOST:  reg_rd_data[4:3] = cfg.mode_sel;
            SEL_INT: begin
                reg_rd_data[IS_DONE] = sts.done;
                reg_rd_data[IS_HALT] = sts.halt;
                reg_rd_data[IS_ERR]  = sts.err_sum;
            end
            SEL_ERR:   reg_rd_data[ES_DESC] = sts.desc_err;
            default:   reg_rd_data = '0;
        endcase
        irq = |sts;
    end

    p_halt_flag_r5: assert property (@(posedge clk) disable iff (rst)
        evt.halt |=> sts.halt);
    p_one_stream_r3: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

endmodule

// File: tb/sdma_engine_tb.sv
module sdma_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_sel = '0;
    logic [31:0] reg_wr_data = '0;
    logic [2:0]  reg_rd_sel = '0;
    logic [31:0] reg_rd_data;
    logic        xfer_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b1;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        irq;

    always #5 clk = ~clk;

    sdma_engine dut_i (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
        .xfer_start(xfer_start), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq(irq)
    );

    localparam logic [2:0] S_ADDR = 3'd0, S_SIZE = 3'd1, S_CNT = 3'd2, S_MODE = 3'd3,
                           S_HOST = 3'd4, S_INT = 3'd5, S_ERR = 3'd6;

    int n_cmp = 0;
    int n_bad = 0;
    int mem_wait = 0;
    int wait_ctr = 0;
    int acc = 0;
    int hs_cnt = 0;
    bit src_hs = 1'b0;
    bit done_flag = 1'b0;

    logic [39:0] exp_mem[$];
    logic [7:0]  exp_out[$];
    logic [7:0]  src_q[$];

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // memory model, output monitor and card-side source
    always @(negedge clk) begin
        if (!rst && mem_req) begin
            if (wait_ctr >= mem_wait) begin
                mem_ack   <= 1'b1;
                mem_rdata <= pat(mem_addr);
                wait_ctr  = 0;
                acc++;
                if (mem_we) begin
                    if (exp_mem.size() == 0) begin
                        chk(1'b0, "R3 unexpected write", mem_addr, 0);
                    end else begin
                        logic [39:0] e;
                        e = exp_mem.pop_front();
                        chk({mem_addr, mem_wdata} == e, "R3 write addr/data", {mem_addr[23:0], mem_wdata}, e[31:0]);
                    end
                end
            end else begin
                mem_ack <= 1'b0;
                wait_ctr++;
            end
        end else begin
            mem_ack  <= 1'b0;
            wait_ctr = 0;
        end
        if (!rst && out_valid && out_ready) begin
            hs_cnt++;
            if (exp_out.size() == 0) begin
                chk(1'b0, "R4 unexpected byte", {24'd0, out_data}, 0);
            end else begin
                logic [7:0] eb;
                eb = exp_out.pop_front();
                chk(out_data == eb, "R4 output byte", {24'd0, out_data}, {24'd0, eb});
            end
        end
        if (src_hs) begin
            void'(src_q.pop_front());
            hs_cnt++;
        end
        in_valid = (src_q.size() > 0);
        in_data  = in_valid ? src_q[0] : 8'h00;
        src_hs   = in_valid && in_ready;
    end

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_rd_sel = sel;
        #1 d = reg_rd_data;
    endtask

    task automatic go();
        @(negedge clk); xfer_start = 1'b1;
        @(negedge clk); xfer_start = 1'b0;
    endtask

    task automatic push_card(input logic [31:0] a, input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = seed + 8'(i * 7);
            src_q.push_back(b);
            exp_mem.push_back({a + 32'(i), b});
        end
    endtask

    task automatic push_out(input logic [31:0] a, input int n);
        for (int i = 0; i < n; i++) exp_out.push_back(pat(a + 32'(i)));
    endtask

    task automatic wait_bit(input int bitpos, input string tag);
        logic [31:0] d;
        int n;
        n = 0;
        do begin rd(S_INT, d); n++; end while (!d[bitpos] && n < 3000);
        chk(d[bitpos], tag, d, 32'd1 << bitpos);
    endtask

    task automatic clear_all();
        wr(S_INT, 32'h0000_800A);
        wr(S_ERR, 32'h0000_0200);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        logic [31:0] d;
        int snap;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(S_INT, d);  chk(d == 0, "R1 int status", d, 0);
        rd(S_ERR, d);  chk(d == 0, "R1 err status", d, 0);
        rd(S_ADDR, d); chk(d == 0, "R1 address", d, 0);
        chk(!mem_req && !in_ready && !out_valid && !irq, "R1 outputs idle",
            {mem_req, in_ready, out_valid, irq}, 0);

        // R2 field layout
        wr(S_SIZE, 32'h0000_F204); rd(S_SIZE, d); chk(d == 32'h7204, "R2 size fields", d, 32'h7204);
        wr(S_MODE, 32'h0000_FFFF); rd(S_MODE, d); chk(d == 32'h37, "R2 mode fields", d, 32'h37);
        wr(S_HOST, 32'h0000_00FF); rd(S_HOST, d); chk(d == 32'h18, "R2 host fields", d, 32'h18);
        wr(S_HOST, 0);

        // R3 card to memory, single block
        wr(S_ADDR, 32'h100); wr(S_SIZE, 32'h5); wr(S_MODE, 32'h11);
        push_card(32'h100, 5, 8'h21);
        go();
        wait_bit(1, "R8 done single block");
        chk(exp_mem.size() == 0, "R3 all writes seen", exp_mem.size(), 0);
        rd(S_ADDR, d); chk(d == 32'h105, "R3 address advanced", d, 32'h105);
        chk(irq == 1'b1, "R10 irq with status", irq, 1);
        wr(S_INT, 32'h0); rd(S_INT, d); chk(d[1] == 1'b1, "R10 write 0 keeps", d, 2);
        wr(S_INT, 32'h2); rd(S_INT, d); chk(d == 0, "R10 write 1 clears", d, 0);
        chk(irq == 1'b0, "R10 irq low", irq, 0);

        // R4 memory to card with slow memory (R12 holds by assertion)
        mem_wait = 2;
        wr(S_ADDR, 32'h40); wr(S_SIZE, 32'h6); wr(S_MODE, 32'h01);
        push_out(32'h40, 6);
        go();
        wait_bit(1, "R4 done");
        chk(exp_out.size() == 0, "R4 all bytes seen", exp_out.size(), 0);
        mem_wait = 0;
        clear_all();

        // R7 R8 multi-block with count
        wr(S_ADDR, 32'h300); wr(S_SIZE, 32'h4); wr(S_CNT, 32'h3); wr(S_MODE, 32'h33);
        push_card(32'h300, 12, 8'h05);
        go();
        wait_bit(1, "R8 done at count zero");
        chk(exp_mem.size() == 0, "R8 three blocks moved", exp_mem.size(), 0);
        rd(S_CNT, d); chk(d == 0, "R7 count decremented", d, 0);
        clear_all();

        // R7 count disabled
        wr(S_ADDR, 32'h500); wr(S_SIZE, 32'h3); wr(S_CNT, 32'h5); wr(S_MODE, 32'h11);
        push_card(32'h500, 3, 8'h77);
        go();
        wait_bit(1, "R8 single block done");
        rd(S_CNT, d); chk(d == 5, "R7 count held", d, 5);
        clear_all();

        // R5 R6 halt at 4 KiB and resume elsewhere
        wr(S_ADDR, 32'hFFC); wr(S_SIZE, 32'h8); wr(S_MODE, 32'h11);
        push_card(32'hFFC, 4, 8'h90);
        push_card(32'h2000, 4, 8'hA3);
        go();
        wait_bit(3, "R5 halt flag");
        rd(S_INT, d); chk(d[1] == 1'b0, "R5 not done at halt", d, 8);
        chk(exp_mem.size() == 4, "R5 halted after four", exp_mem.size(), 4);
        rd(S_ADDR, d); chk(d == 32'h1000, "R6 next address", d, 32'h1000);
        snap = acc;
        repeat (20) @(negedge clk);
        chk(acc == snap, "R6 no access while halted", acc, snap);
        chk(in_ready == 1'b0, "R6 no handshake while halted", in_ready, 0);
        wr(S_INT, 32'h8);
        wr(S_ADDR, 32'h2000);
        wait_bit(1, "R6 resumed to done");
        chk(exp_mem.size() == 0, "R6 resumed writes", exp_mem.size(), 0);
        rd(S_ADDR, d); chk(d == 32'h2004, "R6 final address", d, 32'h2004);
        clear_all();

        // R8 last byte on a boundary completes without halt
        wr(S_ADDR, 32'h1FFC); wr(S_SIZE, 32'h4); wr(S_MODE, 32'h11);
        push_card(32'h1FFC, 4, 8'h11);
        go();
        wait_bit(1, "R8 done on boundary");
        rd(S_INT, d); chk(d[3] == 1'b0, "R8 no halt on last byte", d, 2);
        clear_all();

        // R5 code 1 passes a 4 KiB multiple
        wr(S_ADDR, 32'hFFE); wr(S_SIZE, 32'h1004); wr(S_MODE, 32'h11);
        push_card(32'hFFE, 4, 8'h44);
        go();
        wait_bit(1, "R5 code1 done");
        rd(S_INT, d); chk(d[3] == 1'b0, "R5 code1 no halt", d, 2);
        chk(exp_mem.size() == 0, "R5 code1 writes", exp_mem.size(), 0);
        clear_all();

        // R9 descriptor modes rejected
        wr(S_SIZE, 32'h4); wr(S_MODE, 32'h11); wr(S_HOST, 32'h10);
        snap = acc;
        go();
        repeat (10) @(negedge clk);
        rd(S_ERR, d); chk(d == 32'h200, "R9 error bit", d, 32'h200);
        rd(S_INT, d); chk(d == 32'h8000, "R9 summary only", d, 32'h8000);
        chk(acc == snap && !in_ready, "R9 no transfer", acc, snap);
        clear_all();
        rd(S_INT, d); chk(d == 0, "R10 cleared summary", d, 0);
        rd(S_ERR, d); chk(d == 0, "R10 cleared error", d, 0);
        wr(S_HOST, 32'h08);
        go();
        repeat (3) @(negedge clk);
        rd(S_ERR, d); chk(d == 32'h200, "R9 mode 01 rejected", d, 32'h200);
        clear_all();
        wr(S_HOST, 0);

        // R11 start ignored with DMA disabled
        wr(S_ADDR, 32'h700); wr(S_MODE, 32'h10);
        snap = acc;
        go();
        repeat (10) @(negedge clk);
        chk(acc == snap && !in_ready, "R11 disabled start", acc, snap);
        rd(S_INT, d); chk(d == 0, "R11 no status", d, 0);

        // R11 address write and restart ignored while running
        mem_wait = 3;
        wr(S_ADDR, 32'h600); wr(S_SIZE, 32'h4); wr(S_MODE, 32'h11);
        go();
        wr(S_ADDR, 32'h900);
        go();
        push_card(32'h600, 4, 8'h5A);
        wait_bit(1, "R11 done");
        chk(exp_mem.size() == 0, "R11 address kept", exp_mem.size(), 0);
        rd(S_ADDR, d); chk(d == 32'h604, "R11 final address", d, 32'h604);
        mem_wait = 0;

        repeat (5) @(negedge clk);
        chk(src_q.size() == 0 && exp_out.size() == 0, "R3 queues drained", src_q.size(), 0);
        summary();
    end

endmodule